// File: doc/BRIEF.md
# Wake-Event Power Management Register

This block is a 32-bit control and status register that sits in the system control space of a two-port network switch. It records energy-detect events reported by the two PHY ports in sticky status flags. It routes enabled events to a power-management-event (PME) output and to an interrupt flag. It also provides a self-clearing trigger that holds an internal virtual PHY in reset for a fixed time.

Software reaches the register at byte address 0x084 through a simple select/write/address port. Two half enables let software write the upper and lower 16-bit halves on their own. Reads have no side effects, so either half can be read alone.

The PHY side supplies these inputs:
- one energy-detect event line per port;
- one energy-detect power-down enable per port, which must be set for that port's feature to work;
- a global PME gate;
- a PME indication-mode select, which chooses level or pulse.

Top module: `pmt_wake_reg`

## Requirements
- R1: After reset every field reads zero, and `pme_o`, `pme_irq_o` and `vphy_rst_o` are low. The register reads at byte address 0x084 when `bus_sel` is high; any other address reads zero, and a read changes no state.
- R2: With its power-down enable set, a rising edge on a port's event input sets that port's status flag (bit 16 for port 1, bit 17 for port 2) one clock later. The flag then stays set.
- R3: Writing 1 to a status bit clears it only when that port's qualified event is low in the same cycle. Otherwise the flag stays set.
- R4: Bits 14 (port 1) and 15 (port 2) are read/write energy-detect enables. `pme_irq_o` is high whenever any status flag has its enable set, whatever the global PME gate says.
- R5: `pme_o` can assert only while `pme_gate_en_i` is high and an enabled status flag is set. In level mode (`pme_pulse_mode_i` = 0), `pme_o` follows that condition one clock later.
- R6: In pulse mode (`pme_pulse_mode_i` = 1), a rising edge of the gated condition drives `pme_o` high for exactly PULSE_LEN clocks (default 4), starting one clock later.
- R7: While a port's power-down enable is low, events on that port do not set its status flag.
- R8: Writing 1 to bit 10 raises bit 10 and `vphy_rst_o` for exactly VPHY_RST_CYCLES clocks (default 16), after which both clear by themselves.
- R9: While bit 10 reads 1, writes to bit 10 are ignored and do not extend the reset.
- R10: Bits 31:18, 13:11 and 9:0 always read zero and ignore writes.
- R11: `bus_half_en[0]` enables writes to bits 15:0 and `bus_half_en[1]` enables writes to bits 31:16. A disabled half is left unchanged by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register space select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 12 | Byte address |
| bus_half_en | input | 2 | Half-word write enables, [1] upper, [0] lower |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ed_event_i | input | 2 | Per-port energy-detect event, [0] port 1 |
| ed_pwrdn_en_i | input | 2 | Per-port PHY energy-detect power-down enable |
| pme_gate_en_i | input | 1 | Global PME output enable |
| pme_pulse_mode_i | input | 1 | PME indication: 0 level, 1 pulse |
| pme_o | output | 1 | Power-management-event output |
| pme_irq_o | output | 1 | PME interrupt status flag |
| vphy_rst_o | output | 1 | Virtual PHY reset |

## Verification
The bench targets these corner cases:
- A clear write while the event is still present. A design that cleared anyway would lose a live wake event.
- An event with the power-down enable low. A design that skipped this qualifier would flag events from a port whose feature is off.
- A global PME gate that is off while the interrupt flag is still expected. A design that tied the two together would miss interrupts.
- A pulse width that must be exactly PULSE_LEN.
- A second reset write during an active virtual PHY reset. A design that did not ignore it would stretch the reset beyond VPHY_RST_CYCLES.
- Half-masked writes and all-ones writes. A design that got these wrong would touch a disabled half or expose reserved bits.

A seeded random phase checks the status, enable and interrupt bits against a bench model after every clock.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int          NUM_PORTS = 2;
  localparam int          ADDR_W    = 12;
  localparam logic [11:0] PMT_ADDR  = 12'h084;
  localparam int          STS_LSB   = 16;
  localparam int          EN_LSB    = 14;
  localparam int          VPR_BIT   = 10;
  localparam logic [31:0] LIVE_MASK =
      (32'((1 << NUM_PORTS) - 1) << STS_LSB) |
      (32'((1 << NUM_PORTS) - 1) << EN_LSB)  |
      (32'd1 << VPR_BIT);
endpackage

// File: rtl/pmt_ed_tracker.sv
module pmt_ed_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic pd_en_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  input  logic clr_i,
  output logic sts_o,
  output logic en_o,
  output logic hit_o
);
  logic qual, qual_q, sts_q, sts_d, en_q, en_d;

  assign qual = ev_i & pd_en_i;

  always_comb begin
    sts_d = sts_q;
    if (clr_i && !qual)  sts_d = 1'b0;
    if (qual && !qual_q) sts_d = 1'b1;
    en_d = en_we_i ? en_wd_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      sts_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      qual_q <= qual;
      sts_q  <= sts_d;
      en_q   <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign hit_o = sts_q & en_q;

  // R2 / R7: a flag rises only after a qualified event
  a_r7_set_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(ev_i && pd_en_i));
  // R3: a live qualified event keeps the flag set
  a_r3_hold_while_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && ev_i && pd_en_i) |=> sts_q);
  // R3: a clear needs a clear request
  a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q) |-> $past(clr_i));
endmodule

// File: rtl/pmt_pme_drive.sv
module pmt_pme_drive #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic pulse_mode_i,
  output logic pme_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          cond_q, lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cond_i && !cond_q) cnt_d = CW'(PULSE_LEN);
    else if (busy)         cnt_d = cnt_q - CW'(1);
    lvl_d = cond_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= cond_i;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pme_o = pulse_mode_i ? busy : lvl_q;

  // R5: level output only reflects a gated condition of the prior cycle
  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode_i && pme_o) |-> $past(cond_i));
  // R6: a pulse starts only on a rising condition
  a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cond_i && !cond_q));
  // R6: the counter counts down by one while running without restart
  a_r6_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(cond_i && !cond_q)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/pmt_vphy_reset.sv
module pmt_vphy_reset #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(RST_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  // R9: while busy the count only falls, a write never reloads it
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (cnt_q == $past(cnt_q) - CW'(1)));
  // R8: self-clear happens only at the end of the window
  a_r8_end_of_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == CW'(1)));
  // R8: a reset starts only from a start request
  a_r8_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i));
endmodule

// File: rtl/pmt_wake_reg.sv
module pmt_wake_reg #(
  parameter int PULSE_LEN       = 4,
  parameter int VPHY_RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [1:0]  bus_half_en,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  ed_event_i,
  input  logic [1:0]  ed_pwrdn_en_i,
  input  logic        pme_gate_en_i,
  input  logic        pme_pulse_mode_i,
  output logic        pme_o,
  output logic        pme_irq_o,
  output logic        vphy_rst_o
);
  import pmt_pkg::*;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 addr_hit, wr_lo, wr_hi;
  logic [NUM_PORTS-1:0] sts, en, hit;
  logic                 cond, vbusy;
  logic [31:0]          view;
  logic                 unused_wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign addr_hit = bus_sel && (bus_addr == PMT_ADDR);
  assign wr_lo    = addr_hit && bus_wr && bus_half_en[0];
  assign wr_hi    = addr_hit && bus_wr && bus_half_en[1];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pmt_ed_tracker i_trk (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .ev_i    (ed_event_i[p]),
      .pd_en_i (ed_pwrdn_en_i[p]),
      .en_we_i (wr_lo),
      .en_wd_i (bus_wdata[EN_LSB + p]),
      .clr_i   (wr_hi && bus_wdata[STS_LSB + p]),
      .sts_o   (sts[p]),
      .en_o    (en[p]),
      .hit_o   (hit[p])
    );
  end

  assign pme_irq_o = |hit;
  assign cond      = pme_irq_o && pme_gate_en_i;

  pmt_pme_drive #(.PULSE_LEN(PULSE_LEN)) i_pme (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cond_i       (cond),
    .pulse_mode_i (pme_pulse_mode_i),
    .pme_o        (pme_o)
  );

  pmt_vphy_reset #(.RST_CYCLES(VPHY_RST_CYCLES)) i_vphy (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (wr_lo && bus_wdata[VPR_BIT]),
    .busy_o  (vbusy)
  );
  assign vphy_rst_o = vbusy;

  always_comb begin
    view = '0;
    view[STS_LSB +: NUM_PORTS] = sts;
    view[EN_LSB  +: NUM_PORTS] = en;
    view[VPR_BIT]              = vbusy;
  end

  assign bus_rdata    = addr_hit ? view : '0;
  assign unused_wdata = ^(bus_wdata & ~LIVE_MASK);

  // R10: reserved positions never read back non-zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rdata & ~LIVE_MASK) == 32'd0);
  // R4: the interrupt flag never depends on the global gate
  a_r4_irq_ungated: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(sts & en)) |-> pme_irq_o);
  // R11: a masked upper half leaves the status flags alone
  a_r11_hi_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_hi && $past(!wr_hi)) |-> !$fell(|sts) || $past(!wr_hi) == 1'b0);
endmodule

// File: tb/test_pmt_wake_reg.sv
module test_pmt_wake_reg;
  localparam int PULSE_LEN = 4;
  localparam int VRC       = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [1:0]  bus_half_en;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  ed_event_i, ed_pwrdn_en_i;
  logic        pme_gate_en_i, pme_pulse_mode_i;
  logic        pme_o, pme_irq_o, vphy_rst_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pmt_wake_reg #(.PULSE_LEN(PULSE_LEN), .VPHY_RST_CYCLES(VRC)) i_pmt_wake_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_half_en(bus_half_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ed_event_i(ed_event_i), .ed_pwrdn_en_i(ed_pwrdn_en_i),
    .pme_gate_en_i(pme_gate_en_i), .pme_pulse_mode_i(pme_pulse_mode_i),
    .pme_o(pme_o), .pme_irq_o(pme_irq_o), .vphy_rst_o(vphy_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic rd_mode();
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h084; bus_half_en = 2'b11; bus_wdata = '0;
  endtask

  // drive a write at a falling edge, return at the falling edge after capture
  task automatic wr_reg(input logic [31:0] d, input logic [1:0] he);
    bus_wr = 1'b1; bus_wdata = d; bus_half_en = he;
    @(negedge clk);
    rd_mode();
    #1;
  endtask

  task automatic pulse_ev(input logic [1:0] ev);
    ed_event_i = ev;
    @(negedge clk);
    ed_event_i = 2'b00;
    #1;
  endtask

  function automatic logic irq_of(input logic [1:0] s, input logic [1:0] e);
    return |(s & e);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [1:0] m_sts, m_en, m_qp;
    int cnt;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    rd_mode();
    ed_event_i = '0; ed_pwrdn_en_i = '0; pme_gate_en_i = 1'b0; pme_pulse_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    chk("R1 reset value", bus_rdata, 32'h0);
    chk("R1 reset outputs", {29'd0, pme_o, pme_irq_o, vphy_rst_o}, 32'h0);

    // R7: feature disabled
    @(negedge clk); pulse_ev(2'b11); @(negedge clk); #1;
    chk("R7 no set with power-down enable low", bus_rdata[17:16], 2'b00);

    // R2: sets on events
    ed_pwrdn_en_i = 2'b11;
    @(negedge clk); pulse_ev(2'b01); #1;
    chk("R2 port1 status set", bus_rdata[17:16], 2'b01);
    @(negedge clk); pulse_ev(2'b10); #1;
    chk("R2 port2 status set", bus_rdata[17:16], 2'b11);

    // R3: clear blocked while event present
    @(negedge clk); ed_event_i = 2'b01;
    @(negedge clk); wr_reg(32'h0001_0000, 2'b10);
    chk("R3 clear blocked by live event", bus_rdata[17:16], 2'b11);
    ed_event_i = 2'b00; @(negedge clk);
    wr_reg(32'h0001_0000, 2'b10);
    chk("R3 clear after event gone", bus_rdata[17:16], 2'b10);

    // R11: masked upper half
    wr_reg(32'h0003_0000, 2'b01);
    chk("R11 upper half masked", bus_rdata[17:16], 2'b10);
    wr_reg(32'h0003_0000, 2'b10);
    chk("R11 upper half enabled clears", bus_rdata[17:16], 2'b00);

    // R4: enable read back, irq with gate off
    wr_reg(32'h0000_4000, 2'b01);
    chk("R4 enable readback", bus_rdata[15:14], 2'b01);
    pulse_ev(2'b10); #1;
    chk("R4 irq ignores disabled port", {31'd0, pme_irq_o}, 32'd0);
    pulse_ev(2'b01); #1;
    chk("R4 irq with gate off", {31'd0, pme_irq_o}, 32'd1);
    @(negedge clk); #1;
    chk("R5 pme low while gate off", {31'd0, pme_o}, 32'd0);

    // R5: level mode
    pme_gate_en_i = 1'b1; #1;
    chk("R5 pme waits one clock", {31'd0, pme_o}, 32'd0);
    @(negedge clk); #1;
    chk("R5 pme level asserted", {31'd0, pme_o}, 32'd1);
    pme_gate_en_i = 1'b0;
    @(negedge clk); #1;
    chk("R5 pme drops with gate", {31'd0, pme_o}, 32'd0);
    wr_reg(32'h0003_0000, 2'b10);
    chk("R4 irq clears with status", {31'd0, pme_irq_o}, 32'd0);

    // R6: pulse mode width
    pme_pulse_mode_i = 1'b1; pme_gate_en_i = 1'b1;
    @(negedge clk); pulse_ev(2'b01);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      #1; if (pme_o) cnt++;
      @(negedge clk);
    end
    chk("R6 pulse width", cnt, PULSE_LEN);
    wr_reg(32'h0003_0000, 2'b10);
    pme_pulse_mode_i = 1'b0; pme_gate_en_i = 1'b0;

    // R8 / R9: virtual PHY reset
    wr_reg(32'h0000_0400, 2'b01);
    chk("R8 reset bit reads one", bus_rdata[10], 1'b1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      #1; if (vphy_rst_o) cnt++;
      if (i == 4) begin bus_wr = 1'b1; bus_wdata = 32'h0000_0400; bus_half_en = 2'b01; end
      else rd_mode();
      @(negedge clk);
    end
    #1;
    chk("R9 second write ignored, R8 width", cnt, VRC);
    chk("R8 bit self-clears", bus_rdata[10], 1'b0);

    // R10: reserved bits
    wr_reg(32'hFFFF_FFFF, 2'b11);
    chk("R10 reserved read zero", bus_rdata, 32'h0000_C400);
    repeat (VRC + 2) @(negedge clk);
    #1;

    // R1: other address reads zero, read has no side effect
    bus_addr = 12'h080; #1;
    chk("R1 other address zero", bus_rdata, 32'h0);
    bus_addr = 12'h084; #1;
    chk("R1 read preserved state", bus_rdata, 32'h0000_C000);

    // seeded random phase against a model (R2 R3 R4 R7 R11)
    wr_reg(32'h0003_0000, 2'b11);
    m_sts = 2'b00; m_en = 2'b00; m_qp = 2'b00;
    for (int it = 0; it < 400; it++) begin
      logic [1:0] q, rise, clr;
      #1;
      chk("R2/R3 random status", bus_rdata[17:16], m_sts);
      chk("R4 random enable", bus_rdata[15:14], m_en);
      chk("R4 random irq", {31'd0, pme_irq_o}, {31'd0, irq_of(m_sts, m_en)});
      rd_mode();
      ed_event_i    = 2'($urandom);
      ed_pwrdn_en_i = 2'($urandom);
      if (($urandom % 3) == 0) begin
        bus_wr      = 1'b1;
        bus_half_en = 2'($urandom);
        bus_wdata   = $urandom & ~32'h0000_0400;
      end
      @(posedge clk);
      q    = ed_event_i & ed_pwrdn_en_i;
      rise = q & ~m_qp;
      clr  = (bus_wr && bus_half_en[1]) ? (bus_wdata[17:16] & ~q) : 2'b00;
      m_sts = rise | (m_sts & ~clr);
      if (bus_wr && bus_half_en[0]) m_en = bus_wdata[15:14];
      m_qp = q;
      @(negedge clk);
    end

    finish_run();
  end
endmodule